// File: doc/BRIEF.md
# Serial NOR Flash Bus Transaction Monitor

This block sits beside a byte-level SPI link to a serial NOR flash and only listens. An upstream deserializer gives it a strobe on every chip-select edge and, for each completed byte, the byte seen on each data line with a valid strobe. The monitor takes the first byte of a transaction as the opcode. It then follows the byte position, which has different address, dummy and data phases for each opcode. It collects the 24-bit address, counts payload bytes and raises warning flags.

When chip select changes at the end of a transaction, the monitor gives one single-cycle summary. The summary holds the opcode, the address field, a saturating byte count and the warning bits. The dual-line read is also decoded. In that read, the two bytes sampled in one transfer are merged into two bytes in bus order. One line carries the even bits and the other carries the odd bits.

Top module: `spi_flash_mon`

## Requirements
- R1: After reset, sum_vld_o is low and sum_op_o, sum_addr_o, sum_cnt_o and sum_warn_o are all zero.
- R2: The first byte after a chip-select strobe is the opcode. A chip-select strobe that ends a transaction with at least one byte makes sum_vld_o high for exactly the one cycle after the strobe edge. A strobe with no byte before it makes no summary. A byte presented in the same cycle as a strobe is dropped. Summary fields hold their value between pulses.
- R3: For opcodes 0x03 (read) and 0x02 (program), the MOSI bytes at positions 2, 3 and 4 are shifted into the address from the low end, so the most significant byte comes first. Every later byte adds one to the count.
- R4: For opcode 0x0B (fast read), position 5 is a dummy byte that is not counted. Counting starts at position 6.
- R5: For opcode 0xBB (dual read), each transfer is merged as follows. First byte = {S7,M7,S6,M6,S5,M5,S4,M4} and second byte = {S3,M3,S2,M2,S1,M1,S0,M0}, where M is MOSI and S is MISO. Position 2 shifts in both merged bytes. Position 3 shifts in the first merged byte and drops the second one as the dummy. Each transfer after that adds two to the count.
- R6: For opcode 0x9F (read ID), the MISO bytes at positions 2 to 4 are shifted into the address field: manufacturer first, then type, then device. Each of these bytes adds one to the count. Later bytes are ignored.
- R7: For opcode 0x20 (sector erase), the address comes in at positions 2 to 4. Warning bit 1 is set when the low SECTOR_LG2 address bits are not all zero. The count stays zero and later bytes are ignored.
- R8: For opcode 0x05 (read status), each byte after the opcode adds one to the count. Opcode 0x06 (write enable) reports address 0, count 0 and no warning, and it ignores later bytes.
- R9: Any other opcode sets warning bit 0, reports address 0 and count 0, and ignores later bytes.
- R10: Warning bit 2 is set when the transaction ends before its fixed phases are complete. These phases are: address for 0x03, 0x02, 0x20 and 0x9F; address and dummy for 0x0B; both address transfers for 0xBB. In that case the address field holds only the bytes received.
- R11: The count saturates at 2^CNT_W-1, including when it is incremented by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_chg_i | input | 1 | Chip-select edge strobe |
| byte_vld_i | input | 1 | A byte transfer is present |
| mosi_i | input | 8 | Byte seen on the controller-to-flash line (SIO0) |
| miso_i | input | 8 | Byte seen on the flash-to-controller line (SIO1) |
| sum_vld_o | output | 1 | Summary pulse |
| sum_op_o | output | 8 | Opcode of the finished transaction |
| sum_addr_o | output | 24 | Address or ID field |
| sum_cnt_o | output | CNT_W | Saturating payload byte count |
| sum_warn_o | output | 3 | Bit 0 unknown opcode, bit 1 misaligned erase, bit 2 truncated |

## Verification
The bench builds the monitor with CNT_W=4 and the default SECTOR_LG2=12. The narrow counter lets a read with twenty data bytes reach the saturation limit. It also lets a dual read step from 14 to the cap with a single increment of two. The 4 KiB alignment check is then tested with one aligned and one misaligned erase address. Asymmetric dual-line bit patterns check that the merged bytes come out in the right order.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int ADDR_W  = 24;
  localparam int WARN_W  = 3;
  localparam int W_UNK   = 0;
  localparam int W_ALIGN = 1;
  localparam int W_TRUNC = 2;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DUAL  = 8'hBB;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    K_NONE, K_ADDR_DATA, K_ADDR_DUMMY, K_DUAL, K_ERASE, K_RDID, K_STAT, K_WREN
  } kind_t;

  function automatic kind_t op_kind(logic [7:0] op);
    case (op)
      OP_READ, OP_PROG: op_kind = K_ADDR_DATA;
      OP_FAST:          op_kind = K_ADDR_DUMMY;
      OP_DUAL:          op_kind = K_DUAL;
      OP_ERASE:         op_kind = K_ERASE;
      OP_RDID:          op_kind = K_RDID;
      OP_STAT:          op_kind = K_STAT;
      OP_WREN:          op_kind = K_WREN;
      default:          op_kind = K_NONE;
    endcase
  endfunction

  // next-byte position that must be reached for the fixed phases to be complete
  function automatic logic [2:0] min_pos(kind_t k);
    case (k)
      K_ADDR_DATA, K_ERASE, K_RDID: min_pos = 3'd5;
      K_ADDR_DUMMY:                 min_pos = 3'd6;
      K_DUAL:                       min_pos = 3'd4;
      default:                      min_pos = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_mon_dual.sv
module spi_mon_dual #(
  parameter int NIB = 4
) (
  input  logic [2*NIB-1:0] sio0_i,
  input  logic [2*NIB-1:0] sio1_i,
  output logic [2*NIB-1:0] hi_o,
  output logic [2*NIB-1:0] lo_o
);
  for (genvar i = 0; i < NIB; i++) begin : g_bit
    assign hi_o[2*i]   = sio0_i[NIB+i];
    assign hi_o[2*i+1] = sio1_i[NIB+i];
    assign lo_o[2*i]   = sio0_i[i];
    assign lo_o[2*i+1] = sio1_i[i];
  end
endmodule

// File: rtl/spi_mon_sat_add.sv
module spi_mon_sat_add #(
  parameter int W   = 16,
  parameter int INC = 2
) (
  input  logic [W-1:0]   a_i,
  input  logic [INC-1:0] inc_i,
  output logic [W-1:0]   y_o
);
  logic [W:0] sum;
  assign sum = {1'b0, a_i} + (W+1)'(inc_i);
  assign y_o = sum[W] ? {W{1'b1}} : sum[W-1:0];
endmodule

// File: rtl/spi_flash_mon.sv
module spi_flash_mon
  import spi_mon_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SECTOR_LG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_chg_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        mosi_i,
  input  logic [7:0]        miso_i,
  output logic              sum_vld_o,
  output logic [7:0]        sum_op_o,
  output logic [ADDR_W-1:0] sum_addr_o,
  output logic [CNT_W-1:0]  sum_cnt_o,
  output logic [WARN_W-1:0] sum_warn_o
);
  localparam int POS_W = 3;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic              active_q, active_d, halt_q, halt_d;
  kind_t             kind_q, kind_d, kind_new;
  logic [7:0]        op_q, op_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_sh;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_sum;
  logic [WARN_W-1:0] warn_q, warn_d;
  logic [1:0]        inc_c;
  logic [7:0]        dual_hi, dual_lo;
  logic              take;

  spi_mon_dual #(.NIB(4)) u_dual (
    .sio0_i(mosi_i), .sio1_i(miso_i), .hi_o(dual_hi), .lo_o(dual_lo)
  );

  spi_mon_sat_add #(.W(CNT_W), .INC(2)) u_sat (
    .a_i(cnt_q), .inc_i(inc_c), .y_o(cnt_sum)
  );

  assign kind_new = op_kind(mosi_i);
  assign addr_sh  = {addr_q[ADDR_W-9:0], mosi_i};
  assign take     = byte_vld_i && active_q && !halt_q;

  always_comb begin
    inc_c = 2'd0;
    if (take) begin
      case (kind_q)
        K_ADDR_DATA:  if (pos_q > 3'd4) inc_c = 2'd1;
        K_ADDR_DUMMY: if (pos_q > 3'd5) inc_c = 2'd1;
        K_DUAL:       if (pos_q > 3'd3) inc_c = 2'd2;
        K_RDID, K_STAT: inc_c = 2'd1;
        default: inc_c = 2'd0;
      endcase
    end
  end

  always_comb begin
    active_d = active_q;
    halt_d   = halt_q;
    kind_d   = kind_q;
    op_d     = op_q;
    pos_d    = pos_q;
    addr_d   = addr_q;
    cnt_d    = cnt_sum;
    warn_d   = warn_q;
    if (byte_vld_i && !active_q) begin
      active_d = 1'b1;
      op_d     = mosi_i;
      kind_d   = kind_new;
      pos_d    = 3'd2;
      addr_d   = '0;
      cnt_d    = '0;
      warn_d   = '0;
      halt_d   = (kind_new == K_NONE) || (kind_new == K_WREN);
      if (kind_new == K_NONE) warn_d[W_UNK] = 1'b1;
    end else if (take) begin
      if (pos_q != POS_MAX) pos_d = pos_q + 3'd1;
      case (kind_q)
        K_ADDR_DATA, K_ADDR_DUMMY: if (pos_q <= 3'd4) addr_d = addr_sh;
        K_DUAL: begin
          if (pos_q == 3'd2) addr_d = {addr_q[ADDR_W-17:0], dual_hi, dual_lo};
          else if (pos_q == 3'd3) addr_d = {addr_q[ADDR_W-9:0], dual_hi};
        end
        K_ERASE: begin
          addr_d = addr_sh;
          if (pos_q == 3'd4) begin
            halt_d = 1'b1;
            if (addr_sh[SECTOR_LG2-1:0] != '0) warn_d[W_ALIGN] = 1'b1;
          end
        end
        K_RDID: begin
          addr_d = {addr_q[ADDR_W-9:0], miso_i};
          if (pos_q == 3'd4) halt_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      halt_q     <= 1'b0;
      kind_q     <= K_NONE;
      op_q       <= '0;
      pos_q      <= '0;
      addr_q     <= '0;
      cnt_q      <= '0;
      warn_q     <= '0;
      sum_vld_o  <= 1'b0;
      sum_op_o   <= '0;
      sum_addr_o <= '0;
      sum_cnt_o  <= '0;
      sum_warn_o <= '0;
    end else if (cs_chg_i) begin
      active_q  <= 1'b0;
      halt_q    <= 1'b0;
      sum_vld_o <= active_q;
      if (active_q) begin
        sum_op_o   <= op_q;
        sum_addr_o <= addr_q;
        sum_cnt_o  <= cnt_q;
        sum_warn_o <= warn_q;
        if (pos_q < min_pos(kind_q)) sum_warn_o[W_TRUNC] <= 1'b1;
      end
    end else begin
      active_q  <= active_d;
      halt_q    <= halt_d;
      kind_q    <= kind_d;
      op_q      <= op_d;
      pos_q     <= pos_d;
      addr_q    <= addr_d;
      cnt_q     <= cnt_d;
      warn_q    <= warn_d;
      sum_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flash_mon_chk.sv
module spi_flash_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_chg_i,
  input logic              sum_vld_o,
  input logic [7:0]        sum_op_o,
  input logic [23:0]       sum_addr_o,
  input logic [CNT_W-1:0]  sum_cnt_o,
  input logic [2:0]        sum_warn_o
);
  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vld_o |=> !sum_vld_o);

  p_after_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vld_o |-> $past(cs_chg_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum_vld_o |-> ($stable(sum_addr_o) && $stable(sum_cnt_o) && $stable(sum_op_o)));

  p_align_erase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_o && sum_warn_o[1]) |-> (sum_op_o == 8'h20));

  p_unknown_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_o && sum_warn_o[0]) |-> (sum_addr_o == '0 && sum_cnt_o == '0));

  p_wren_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_o && sum_op_o == 8'h06) |-> (sum_warn_o == '0 && sum_cnt_o == '0));
endmodule

bind spi_flash_mon spi_flash_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_chg_i(cs_chg_i), .sum_vld_o(sum_vld_o),
  .sum_op_o(sum_op_o), .sum_addr_o(sum_addr_o), .sum_cnt_o(sum_cnt_o),
  .sum_warn_o(sum_warn_o)
);

// File: tb/sim_spi_flash_mon.sv
module sim_spi_flash_mon;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0, cs_chg_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] mosi_i = '0, miso_i = '0;
  logic sum_vld_o;
  logic [7:0] sum_op_o;
  logic [23:0] sum_addr_o;
  logic [CNT_W-1:0] sum_cnt_o;
  logic [2:0] sum_warn_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic g_vld, g_after;
  logic [7:0] g_op;
  logic [23:0] g_addr;
  logic [15:0] g_cnt;
  logic [2:0] g_warn;

  always #4 clk = ~clk;

  spi_flash_mon #(.CNT_W(CNT_W), .SECTOR_LG2(12)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_chg_i(cs_chg_i), .byte_vld_i(byte_vld_i),
    .mosi_i(mosi_i), .miso_i(miso_i), .sum_vld_o(sum_vld_o), .sum_op_o(sum_op_o),
    .sum_addr_o(sum_addr_o), .sum_cnt_o(sum_cnt_o), .sum_warn_o(sum_warn_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  n;
    logic [63:0] mosi;
    logic [63:0] miso;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [15:0] cnt;
    logic [2:0]  warn;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 4'd6, 64'h03123456AABB0000, 64'h0, 8'h03, 24'h123456, 16'd2, 3'b000}, // R3 read
    '{4'd3, 4'd7, 64'h0200010011223300, 64'h0, 8'h02, 24'h000100, 16'd3, 3'b000}, // R3 program
    '{4'd4, 4'd7, 64'h0BABCDEF00010200, 64'h0, 8'h0B, 24'hABCDEF, 16'd2, 3'b000}, // R4 fast read
    '{4'd7, 4'd4, 64'h2001300000000000, 64'h0, 8'h20, 24'h013000, 16'd0, 3'b000}, // R7 aligned
    '{4'd7, 4'd5, 64'h20013010FF000000, 64'h0, 8'h20, 24'h013010, 16'd0, 3'b010}, // R7 misaligned
    '{4'd6, 4'd5, 64'h9F00000000000000, 64'h00EF401877000000, 8'h9F, 24'hEF4018, 16'd3, 3'b000}, // R6
    '{4'd8, 4'd4, 64'h0500000000000000, 64'h0, 8'h05, 24'h000000, 16'd3, 3'b000}, // R8 status
    '{4'd8, 4'd1, 64'h0600000000000000, 64'h0, 8'h06, 24'h000000, 16'd0, 3'b000}, // R8 wren
    '{4'd9, 4'd3, 64'h5A11220000000000, 64'h0, 8'h5A, 24'h000000, 16'd0, 3'b001}, // R9 unknown
    '{4'd10, 4'd2, 64'h0312000000000000, 64'h0, 8'h03, 24'h000012, 16'd0, 3'b100}, // R10 read
    '{4'd5, 4'd5, 64'hBB3C0F0000000000, 64'h0000F00000000000, 8'hBB, 24'h0550AA, 16'd4, 3'b000}, // R5 dual
    '{4'd10, 4'd2, 64'hBB3C000000000000, 64'h0, 8'hBB, 24'h000550, 16'd0, 3'b100}, // R10 dual
    '{4'd10, 4'd4, 64'h0B01020300000000, 64'h0, 8'h0B, 24'h010203, 16'd0, 3'b100}  // R10 fast
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] m, logic [7:0] s);
    byte_vld_i = 1'b1; mosi_i = m; miso_i = s;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic end_txn();
    cs_chg_i = 1'b1;
    @(negedge clk);
    cs_chg_i = 1'b0; byte_vld_i = 1'b0;
    g_vld = sum_vld_o; g_op = sum_op_o; g_addr = sum_addr_o;
    g_cnt = 16'(sum_cnt_o); g_warn = sum_warn_o;
    @(negedge clk);
    g_after = sum_vld_o;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 vld", 32'(sum_vld_o), 0);
    chk("R1 op", 32'(sum_op_o), 0);
    chk("R1 addr", 32'(sum_addr_o), 0);
    chk("R1 cnt", 32'(sum_cnt_o), 0);
    chk("R1 warn", 32'(sum_warn_o), 0);

    // R2 empty transaction makes no summary
    end_txn();
    chk("R2 empty", 32'(g_vld), 0);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VEC[v].n); i++)
        send(VEC[v].mosi[63-8*i -: 8], VEC[v].miso[63-8*i -: 8]);
      end_txn();
      $display("vector %0d checks req R%0d", v, VEC[v].req);
      chk("R2 vld", 32'(g_vld), 1);
      chk("R2 pulse", 32'(g_after), 0);
      chk("vec op", 32'(g_op), 32'(VEC[v].op));
      chk("vec addr", 32'(g_addr), 32'(VEC[v].addr));
      chk("vec cnt", 32'(g_cnt), 32'(VEC[v].cnt));
      chk("vec warn", 32'(g_warn), 32'(VEC[v].warn));
    end

    // R11 read with 20 data bytes saturates at 15
    send(8'h03, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
    for (int i = 0; i < 20; i++) send(8'(i), 8'h00);
    end_txn();
    chk("R11 read sat", 32'(g_cnt), 15);

    // R11 dual: 7 pairs -> 14, 8 pairs -> capped 15
    send(8'hBB, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
    for (int i = 0; i < 7; i++) send(8'h00, 8'h00);
    end_txn();
    chk("R11 dual 14", 32'(g_cnt), 14);
    send(8'hBB, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00);
    end_txn();
    chk("R11 dual cap", 32'(g_cnt), 15);

    // R2 byte coincident with chip-select strobe is dropped
    send(8'h06, 8'h00);
    byte_vld_i = 1'b1; mosi_i = 8'h03;
    end_txn();
    chk("R2 coincident op", 32'(g_op), 32'h06);
    send(8'h05, 8'h00); send(8'h00, 8'h00);
    end_txn();
    chk("R2 next opcode", 32'(g_op), 32'h05);
    chk("R2 next cnt", 32'(g_cnt), 1);
    chk("R2 next warn", 32'(g_warn), 0);

    // R2 fields held after pulse
    repeat (3) @(negedge clk);
    chk("R2 hold addr", 32'(sum_op_o), 32'h05);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule